// File: doc/BRIEF.md
# Tightly-coupled memory wait-state controller

This controller joins a processor's tightly-coupled memory request port to a small synchronous word memory. It decides cycle by cycle whether the core must be stalled. It drives a single wait output that covers two cases: the one-cycle latency of a nonsequential access, and the time during which a DMA requester holds the memory. Sequential accesses run at full rate. A nonsequential access costs one wait state. After that wait state the core repeats its request as sequential, and the controller ignores that repeat.

The address, chip select, sequential flag and write enable of the core are valid only in the cycle that carries the request. Whenever the controller cannot serve a request at once, it registers these attributes at the end of that cycle. It then replays the access from the registered copy once the memory is free. Write data follows its request by one cycle and is not registered with the attributes. The DMA port wins over any core request that is waiting. Each DMA transfer takes one wait state and then an acknowledge pulse.

Top module: `tcm_wait_ctrl`

## Requirements
- R1: After reset the controller is idle: `core_wait` and `dma_ack` are low, both read-data outputs are zero and no core request is held.
- R2: A core request with `core_seq` low, in an idle cycle with no DMA request, raises `core_wait` in that same cycle. In the next cycle `core_wait` is low and the core's inputs are ignored. Read data appears on `core_rdata` one cycle after that.
- R3: A core request with `core_seq` high, in an idle cycle with no DMA request, leaves `core_wait` low and returns its read data on `core_rdata` in the next cycle. Back-to-back sequential requests run with no gap.
- R4: Core write data is sampled one cycle after its request: in the access cycle of a nonsequential write, or in the following cycle of a sequential write. A later read of the same word returns it, including a read issued in the very cycle the write lands.
- R5: While `core_cs` is low and the controller is idle, `core_seq`, `core_we` and `core_addr` have no effect: `core_wait` stays low and no memory word changes.
- R6: A DMA request seen in an idle cycle T gets exactly one wait cycle. `dma_ack` is high for a single cycle at T+2, and the word read appears on `dma_rdata` from T+3. The requester holds its request until the acknowledge and drops it in the cycle after.
- R7: A core request in the same idle cycle as a DMA request, whether sequential or not, loses. `core_wait` stays high from that cycle through the DMA acknowledge. The core's attributes are taken from its request cycle only. The access is then replayed in the next cycle with `core_wait` low, and a postponed write takes `core_wdata` in that replay cycle.
- R8: A core request issued while a DMA transfer is already in progress is captured, stalled and replayed the same way, in the cycle after the acknowledge.
- R9: `core_rdata` changes only after a core read, and `dma_rdata` changes only after a DMA read. Each output holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_cs | input | 1 | Core request strobe |
| core_seq | input | 1 | Core request continues the previous address |
| core_we | input | 1 | Core request is a write |
| core_addr | input | ADDR_W | Core word address |
| core_wdata | input | DATA_W | Core write data, one cycle after the request |
| core_rdata | output | DATA_W | Core read data, held until the next core read |
| core_wait | output | 1 | Stall to the core |
| dma_req | input | 1 | DMA transfer request, held until acknowledged |
| dma_we | input | 1 | DMA transfer is a write |
| dma_addr | input | ADDR_W | DMA word address |
| dma_wdata | input | DATA_W | DMA write data |
| dma_rdata | output | DATA_W | DMA read data, held until the next DMA read |
| dma_ack | output | 1 | One-cycle acknowledge of a DMA transfer |

## Verification
The collision that matters is a core request and a DMA request in the same idle cycle. A second case is a core request arriving while a DMA transfer is mid-way. Directed sequences provoke both, with sequential and nonsequential core requests and with reads and writes on each side. The core's address and write enable are scrambled after the request cycle, so that a design that samples them late is caught. The bench judges the result from the cycle in which each output must move, from the words read back on both ports, and from a shadow memory that random core traffic keeps current.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CORE_ACC = 2'd1,
        ST_DMA_WS   = 2'd2,
        ST_DMA_ACC  = 2'd3
    } arb_state_e;

    typedef enum logic {
        RD_TO_CORE = 1'b0,
        RD_TO_DMA  = 1'b1
    } rd_dest_e;

    function automatic logic dma_busy(arb_state_e st);
        return (st == ST_DMA_WS) || (st == ST_DMA_ACC);
    endfunction

endpackage

// File: rtl/tcm_req_latch.sv
module tcm_req_latch #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              replay_done,
    input  logic              in_we,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              held_we,
    output logic [ADDR_W-1:0] held_addr,
    output logic              pend_q
);
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } held_req_t;

    held_req_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (cap_en) begin
                req_q.wr   <= in_we;
                req_q.addr <= in_addr;
            end
            if (cap_en)
                pend_q <= 1'b1;
            else if (replay_done)
                pend_q <= 1'b0;
        end
    end

    assign held_we   = req_q.wr;
    assign held_addr = req_q.addr;

    a_r7_capture_stable: assert property (@(posedge clk) disable iff (rst)
        (pend_q && $past(pend_q)) |-> $stable(req_q));

endmodule

// File: rtl/tcm_sram.sv
module tcm_sram #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  tcm_pkg::rd_dest_e rd_dest,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] core_q,
    output logic [DATA_W-1:0] dma_q
);
    import tcm_pkg::*;

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        if (wr_en && (wr_addr == rd_addr))
            rd_val = wr_data;
        else
            rd_val = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
            dma_q  <= '0;
        end else if (rd_en) begin
            if (rd_dest == RD_TO_DMA)
                dma_q <= rd_val;
            else
                core_q <= rd_val;
        end
    end

endmodule

// File: rtl/tcm_arb_fsm.sv
module tcm_arb_fsm (
    input  logic                clk,
    input  logic                rst,
    input  logic                core_cs,
    input  logic                core_seq,
    input  logic                core_we,
    input  logic                dma_req,
    input  logic                pend_q,
    output tcm_pkg::arb_state_e state_q,
    output logic                core_wait,
    output logic                cap_en,
    output logic                seq_rd,
    output logic                seq_wr,
    output logic                dma_ack
);
    import tcm_pkg::*;

    arb_state_e state_d;
    logic       idle;
    logic       seq_go;

    assign idle    = (state_q == ST_IDLE);
    assign seq_go  = idle && core_cs && core_seq && !dma_req;
    assign seq_rd  = seq_go && !core_we;
    assign seq_wr  = seq_go && core_we;
    assign cap_en  = (idle && core_cs && (!core_seq || dma_req))
                   || (dma_busy(state_q) && core_cs && !pend_q);
    assign dma_ack = (state_q == ST_DMA_ACC);
    assign core_wait = cap_en || (pend_q && (state_q != ST_CORE_ACC));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dma_req)
                    state_d = ST_DMA_WS;
                else if (core_cs && !core_seq)
                    state_d = ST_CORE_ACC;
            end
            ST_CORE_ACC: state_d = ST_IDLE;
            ST_DMA_WS:   state_d = ST_DMA_ACC;
            ST_DMA_ACC:  state_d = (pend_q || cap_en) ? ST_CORE_ACC : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    a_r2_release_after_ws: assert property (@(posedge clk) disable iff (rst)
        (idle && core_cs && !core_seq && !dma_req) |=> !core_wait);

    a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
        dma_ack |=> !dma_ack);

    a_r6_ack_after_ws: assert property (@(posedge clk) disable iff (rst)
        dma_ack |-> ($past(state_q) == ST_DMA_WS));

    a_r7_dma_wins: assert property (@(posedge clk) disable iff (rst)
        (idle && dma_req && core_cs) |=> (state_q == ST_DMA_WS && pend_q && core_wait));

    a_r8_replay_after_ack: assert property (@(posedge clk) disable iff (rst)
        (dma_ack && pend_q) |=> (state_q == ST_CORE_ACC && !core_wait));

endmodule

// File: rtl/tcm_wait_ctrl.sv
module tcm_wait_ctrl #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_cs,
    input  logic              core_seq,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_wait,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              dma_ack
);
    import tcm_pkg::*;

    arb_state_e        state_q;
    logic              cap_en;
    logic              seq_rd;
    logic              seq_wr;
    logic              pend_q;
    logic              held_we;
    logic [ADDR_W-1:0] held_addr;
    logic              core_acc;

    logic              wr_pend_q;
    logic [ADDR_W-1:0] wr_addr_q;

    logic              mem_wr_en;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [DATA_W-1:0] mem_wr_data;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    rd_dest_e          mem_rd_dest;

    tcm_arb_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .core_cs   (core_cs),
        .core_seq  (core_seq),
        .core_we   (core_we),
        .dma_req   (dma_req),
        .pend_q    (pend_q),
        .state_q   (state_q),
        .core_wait (core_wait),
        .cap_en    (cap_en),
        .seq_rd    (seq_rd),
        .seq_wr    (seq_wr),
        .dma_ack   (dma_ack)
    );

    assign core_acc = (state_q == ST_CORE_ACC);

    tcm_req_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk         (clk),
        .rst         (rst),
        .cap_en      (cap_en),
        .replay_done (core_acc),
        .in_we       (core_we),
        .in_addr     (core_addr),
        .held_we     (held_we),
        .held_addr   (held_addr),
        .pend_q      (pend_q)
    );

    // sequential write: address now, data one cycle later
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pend_q <= 1'b0;
            wr_addr_q <= '0;
        end else begin
            wr_pend_q <= seq_wr;
            if (seq_wr)
                wr_addr_q <= core_addr;
        end
    end

    always_comb begin
        mem_wr_en   = wr_pend_q || (core_acc && held_we) || (dma_ack && dma_we);
        mem_wr_addr = wr_pend_q ? wr_addr_q : (core_acc ? held_addr : dma_addr);
        mem_wr_data = dma_ack ? dma_wdata : core_wdata;
        mem_rd_en   = seq_rd || (core_acc && !held_we) || (dma_ack && !dma_we);
        mem_rd_addr = seq_rd ? core_addr : (core_acc ? held_addr : dma_addr);
        mem_rd_dest = dma_ack ? RD_TO_DMA : RD_TO_CORE;
    end

    tcm_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mem_wr_en),
        .wr_addr (mem_wr_addr),
        .wr_data (mem_wr_data),
        .rd_en   (mem_rd_en),
        .rd_dest (mem_rd_dest),
        .rd_addr (mem_rd_addr),
        .core_q  (core_rdata),
        .dma_q   (dma_rdata)
    );

    a_r4_one_writer: assert property (@(posedge clk) disable iff (rst)
        !(wr_pend_q && ((core_acc && held_we) || dma_ack)));

    a_r5_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !core_cs && !dma_req && !wr_pend_q)
            |-> (!mem_wr_en && !mem_rd_en && !core_wait));

    a_r9_core_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(mem_rd_en && mem_rd_dest == RD_TO_CORE) |-> $stable(core_rdata));

endmodule

// File: tb/test_tcm_wait_ctrl.sv
module test_tcm_wait_ctrl;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          core_cs = 0, core_seq = 0, core_we = 0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic [DW-1:0] core_rdata;
    logic          core_wait;
    logic          dma_req = 0, dma_we = 0;
    logic [AW-1:0] dma_addr = '0;
    logic [DW-1:0] dma_wdata = '0;
    logic [DW-1:0] dma_rdata;
    logic          dma_ack;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] shadow [DEPTH];

    always #10 clk = ~clk;

    tcm_wait_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_tcm_wait_ctrl (
        .clk(clk), .rst(rst),
        .core_cs(core_cs), .core_seq(core_seq), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .core_wait(core_wait),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .dma_ack(dma_ack)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int unsigned a, input int unsigned salt);
        return {a[7:0], salt[7:0], 16'hA5C3} ^ (salt * 32'h9E37_79B9);
    endfunction

    task automatic idle_inputs();
        core_cs  = 1'b0;
        core_seq = 1'($urandom);
        core_we  = 1'($urandom);
        core_addr = AW'($urandom);
        dma_req  = 1'b0;
    endtask

    // one core access followed by one quiet cycle in which read data is judged
    task automatic core_op(input logic [AW-1:0] a, input logic w, input logic s,
                           input logic [DW-1:0] d);
        @(negedge clk);
        core_cs = 1'b1; core_seq = s; core_we = w; core_addr = a; core_wdata = '0;
        #5;
        chk(s ? "R3 wait in seq request" : "R2 wait in nonseq request", DW'(core_wait), DW'(!s));
        if (!s) begin
            @(negedge clk);
            core_cs = 1'b1; core_seq = 1'b1; core_we = ~w; core_addr = ~a; core_wdata = d;
            #5;
            chk("R2 wait released after wait state", DW'(core_wait), '0);
        end
        @(negedge clk);
        idle_inputs();
        core_wdata = s ? d : ~d;
        #1;
        if (w) shadow[a] = d;
        else chk(s ? "R3 seq read data" : "R2 nonseq read data", core_rdata, shadow[a]);
        #4;
        chk("R5 no wait without request", DW'(core_wait), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] prev;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        #5;
        chk("R1 wait low in reset", DW'(core_wait), '0);
        rst = 1'b0;
        @(negedge clk); #5;
        chk("R1 wait low after reset", DW'(core_wait), '0);
        chk("R1 ack low after reset", DW'(dma_ack), '0);
        chk("R1 core rdata zero", core_rdata, '0);
        chk("R1 dma rdata zero", dma_rdata, '0);

        // R4: fill the memory with mixed sequential and nonsequential writes
        for (int i = 0; i < DEPTH; i++)
            core_op(AW'(i), 1'b1, 1'(i % 3 == 0), pattern(i, 1));
        for (int i = 0; i < DEPTH; i += 7)
            core_op(AW'(i), 1'b0, 1'(i % 2), '0);

        // R2/R3: back-to-back nonseq A then seq A+1
        @(negedge clk);
        core_cs = 1; core_seq = 0; core_we = 0; core_addr = 6'd10; #5;
        chk("R2 wait on nonseq A", DW'(core_wait), 32'd1);
        @(negedge clk);
        core_seq = 1; core_addr = 6'd33; #5;
        chk("R2 wait low on repeat of A", DW'(core_wait), '0);
        @(negedge clk);
        core_seq = 1; core_addr = 6'd11; #5;
        chk("R3 no wait on seq A+1", DW'(core_wait), '0);
        chk("R2 data of A", core_rdata, shadow[10]);
        @(negedge clk);
        idle_inputs(); #5;
        chk("R3 data of A+1", core_rdata, shadow[11]);

        // R4: sequential write then immediate sequential read of the same word
        @(negedge clk);
        core_cs = 1; core_seq = 1; core_we = 1; core_addr = 6'd20;
        @(negedge clk);
        core_wdata = 32'hCAFE_0020; core_cs = 1; core_seq = 1; core_we = 0; core_addr = 6'd20;
        shadow[20] = 32'hCAFE_0020;
        @(negedge clk);
        idle_inputs(); #5;
        chk("R4 read in cycle the write lands", core_rdata, 32'hCAFE_0020);

        // R5: idle cycles with seq/we/addr toggling do not write
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            idle_inputs(); core_we = 1; core_addr = 6'd5; core_wdata = 32'hDEAD_BEEF;
        end
        core_op(6'd5, 1'b0, 1'b0, '0);

        // R6 + R9: DMA read alone
        prev = core_rdata;
        @(negedge clk);
        dma_req = 1; dma_we = 0; dma_addr = 6'd40; #5;
        chk("R6 no ack at T", DW'(dma_ack), '0);
        @(negedge clk); #5;
        chk("R6 no ack at T+1", DW'(dma_ack), '0);
        @(negedge clk); #5;
        chk("R6 ack at T+2", DW'(dma_ack), 32'd1);
        @(negedge clk);
        dma_req = 0; #5;
        chk("R6 ack single pulse", DW'(dma_ack), '0);
        chk("R6 dma read data", dma_rdata, shadow[40]);
        chk("R9 core rdata held over dma read", core_rdata, prev);

        // R7: seq core read collides with DMA read
        prev = core_rdata;
        @(negedge clk);
        dma_req = 1; dma_we = 0; dma_addr = 6'd41;
        core_cs = 1; core_seq = 1; core_we = 0; core_addr = 6'd42; #5;
        chk("R7 stall on collision", DW'(core_wait), 32'd1);
        @(negedge clk);
        core_cs = 1; core_seq = 1; core_we = 1; core_addr = 6'd3; #5;
        chk("R7 stall in dma wait state", DW'(core_wait), 32'd1);
        @(negedge clk); #5;
        chk("R7 stall in dma ack cycle", DW'(core_wait), 32'd1);
        chk("R7 ack", DW'(dma_ack), 32'd1);
        @(negedge clk);
        dma_req = 0; #5;
        chk("R7 replay without wait", DW'(core_wait), '0);
        chk("R9 core rdata before replay", core_rdata, prev);
        chk("R9 dma rdata", dma_rdata, shadow[41]);
        @(negedge clk);
        idle_inputs(); #5;
        chk("R7 replayed read data", core_rdata, shadow[42]);
        chk("R9 dma rdata held over core read", dma_rdata, shadow[41]);

        // R7: nonseq core write collides with DMA write
        @(negedge clk);
        dma_req = 1; dma_we = 1; dma_addr = 6'd50; dma_wdata = 32'h0D0A_0050;
        core_cs = 1; core_seq = 0; core_we = 1; core_addr = 6'd51; #5;
        chk("R7 stall on write collision", DW'(core_wait), 32'd1);
        @(negedge clk);
        core_cs = 1; core_seq = 1; core_we = 0; core_addr = 6'd2; core_wdata = 32'h0C0E_0051;
        @(negedge clk); #5;
        chk("R7 dma write ack", DW'(dma_ack), 32'd1);
        @(negedge clk);
        dma_req = 0; #5;
        chk("R7 write replay without wait", DW'(core_wait), '0);
        shadow[50] = 32'h0D0A_0050; shadow[51] = 32'h0C0E_0051;
        @(negedge clk);
        idle_inputs();
        core_op(6'd51, 1'b0, 1'b1, '0);
        core_op(6'd50, 1'b0, 1'b0, '0);
        core_op(6'd2, 1'b0, 1'b1, '0);

        // R8: core request arrives while DMA is in its wait state
        @(negedge clk);
        dma_req = 1; dma_we = 0; dma_addr = 6'd60; #5;
        chk("R8 no stall without request", DW'(core_wait), '0);
        @(negedge clk);
        core_cs = 1; core_seq = 0; core_we = 0; core_addr = 6'd61; #5;
        chk("R8 stall on late core request", DW'(core_wait), 32'd1);
        @(negedge clk);
        core_cs = 1; core_seq = 1; core_addr = 6'd0; #5;
        chk("R8 stall through ack", DW'(core_wait), 32'd1);
        chk("R8 ack", DW'(dma_ack), 32'd1);
        @(negedge clk);
        dma_req = 0; #5;
        chk("R8 replay", DW'(core_wait), '0);
        @(negedge clk);
        idle_inputs(); #5;
        chk("R8 replayed data", core_rdata, shadow[61]);
        chk("R8 dma data", dma_rdata, shadow[60]);

        // random core traffic against the shadow memory
        for (int i = 0; i < 300; i++)
            core_op(AW'($urandom), 1'($urandom % 3 == 0), 1'($urandom), $urandom);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule